// File: doc/BRIEF.md
# Flash Bank Operation Arbiter

This block sits between a request source and the program/erase engine of a banked flash array. Each request carries a word address and an operation. The address is decoded in the same cycle into a bank index and a block index. One bank of the array is a parameter bank, made of eight small blocks and seven full-size blocks. A strap selects whether that bank sits at the top or the bottom of the address map. A second strap selects the 16 Mbit or 32 Mbit array size.

The arbiter tracks the single program or erase that may be in flight. It also tracks a suspended erase that has been set aside for a nested program. From that state it decides whether each request may start. The verdict, grant or reject, appears one clock after the request. The engine reports completion, suspend and resume through single-cycle strobes.

Top module: `flash_bank_arbiter`

## Requirements
- R1: `bank_idx` is address bits [20:18] when `size_32m` is 1. When `size_32m` is 0 it is bits [19:18], and address bit 20 has no effect on either index.
- R2: With `boot_top`=0, bank 0 is the parameter bank. Within it, word offsets 0 to 32767 form blocks 0-7, one per 4K words, selected by address bits [14:12]. Bits [17:15] values 1-7 give blocks 8-14. Any other bank b gives block 15 + 8*(b-1) + bits[17:15]. This makes 39 blocks at 16 Mbit and 71 at 32 Mbit.
- R3: With `boot_top`=1, the highest bank (3 or 7) is the parameter bank. For bank b, bits [17:15] values 0-6 give block 8*b + bits[17:15]. In the parameter bank, bits [17:15]=7 selects block 8*b + 7 + bits[14:12]. In any other bank it selects block 8*b + 7.
- R4: A request sampled at a rising edge produces exactly one of `grant` or `reject`, high for the following cycle. With no request, both are low in the following cycle, and both are low out of reset.
- R5: After reset no operation is active, so a program (`req_op`=1) or erase (`req_op`=2) request is granted.
- R6: The following are rejected: an erase while any operation is active or suspended, a program while a program is active, suspended or not, and the reserved code `req_op`=3.
- R7: While a program or erase runs unsuspended, a read (`req_op`=0) to any other bank is granted, and a read to the same bank is rejected.
- R8: While the active program is suspended, a read to any block other than the one being programmed is granted, including blocks of the same bank. A read to the block being programmed is rejected.
- R9: While an erase is suspended, a program to a different block is granted and starts at once. A program to the block being erased is rejected.
- R10: When a nested program completes, the set-aside erase becomes the active operation again, still suspended. A further program to another block is then allowed, and the erase finishes only after `eng_resume` and `eng_done`.
- R11: `eng_done` while the active operation is unsuspended and no erase is set aside returns the arbiter to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 0 read, 1 program, 2 erase, 3 reserved |
| req_addr | input | 21 | Word address |
| boot_top | input | 1 | 1: parameter bank at highest addresses; 0: at lowest |
| size_32m | input | 1 | 1: 32 Mbit array (8 banks); 0: 16 Mbit (4 banks) |
| eng_done | input | 1 | Active program/erase completed |
| eng_suspend | input | 1 | Active program/erase suspended |
| eng_resume | input | 1 | Suspended operation resumed |
| grant | output | 1 | Previous cycle's request accepted |
| reject | output | 1 | Previous cycle's request refused |
| bank_idx | output | 3 | Decoded bank of `req_addr` |
| block_idx | output | 7 | Decoded block of `req_addr` |

## Verification
The decoder is exercised with addresses at the edges of every region: each small block, the first and last full blocks of the parameter bank, and ordinary banks. Each address is tried in both boot positions and both sizes, so a mistake in the placement of the small blocks, an off-by-one at the parameter bank boundary, or a leak of address bit 20 in the small array each shows up as a wrong index. Grant decisions are driven through three sequences: plain busy, program suspend, and erase suspend with a nested program. Reads are placed in the same block, the same bank and a foreign bank, which separates bank-level blocking from block-level blocking. Completing the nested program before resuming shows whether the set-aside erase is restored or lost.

// File: rtl/flash_arb_pkg.sv
package flash_arb_pkg;

    // Address geometry, all in 16-bit words
    localparam int ADDR_W     = 21;
    localparam int BANK_LOG2  = 18;
    localparam int MAIN_LOG2  = 15;
    localparam int PARAM_LOG2 = 12;

    localparam int BANK_W       = ADDR_W - BANK_LOG2;
    localparam int MAX_BANKS    = 1 << BANK_W;
    localparam int SUB_W        = BANK_LOG2 - MAIN_LOG2;
    localparam int BLK_PER_BANK = 1 << SUB_W;
    localparam int PAR_W        = MAIN_LOG2 - PARAM_LOG2;
    localparam int PARAM_BLKS   = 1 << PAR_W;
    localparam int MAX_BLOCKS   = MAX_BANKS * BLK_PER_BANK - 1 + PARAM_BLKS;
    localparam int BLK_W        = $clog2(MAX_BLOCKS);

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_PROG  = 2'd1,
        OP_ERASE = 2'd2,
        OP_RSVD  = 2'd3
    } op_e;

    typedef logic [BANK_W-1:0] bank_t;
    typedef logic [BLK_W-1:0]  block_t;

    // One tracked program/erase
    typedef struct packed {
        logic   valid;
        op_e    op;
        bank_t  bank;
        block_t block;
        logic   susp;
    } slot_t;

    typedef struct packed {
        logic grant;
        logic reject;
        logic start;
        logic nest;
    } verdict_t;

    function automatic bank_t highest_bank(input logic big);
        return big ? bank_t'(MAX_BANKS - 1) : bank_t'(MAX_BANKS / 2 - 1);
    endfunction

    function automatic bank_t fold_bank(input bank_t raw, input logic big);
        return big ? raw : (raw & bank_t'(MAX_BANKS / 2 - 1));
    endfunction

endpackage

// File: rtl/flash_addr_decode.sv
module flash_addr_decode
    import flash_arb_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              boot_top,
    input  logic              size_32m,
    output bank_t             bank,
    output block_t            block
);

    bank_t top_bank;
    int    b_i;
    int    sub_i;
    int    par_i;
    int    blk_i;

    logic unused_low;
    assign unused_low = ^addr[PARAM_LOG2-1:0];

    always_comb begin
        bank     = fold_bank(addr[ADDR_W-1:BANK_LOG2], size_32m);
        top_bank = highest_bank(size_32m);
        b_i      = int'(bank);
        sub_i    = int'(addr[BANK_LOG2-1:MAIN_LOG2]);
        par_i    = int'(addr[MAIN_LOG2-1:PARAM_LOG2]);
        if (boot_top) begin
            if (bank == top_bank && sub_i == BLK_PER_BANK - 1)
                blk_i = b_i * BLK_PER_BANK + BLK_PER_BANK - 1 + par_i;
            else
                blk_i = b_i * BLK_PER_BANK + sub_i;
        end else begin
            if (b_i == 0)
                blk_i = (sub_i == 0) ? par_i : PARAM_BLKS - 1 + sub_i;
            else
                blk_i = PARAM_BLKS + BLK_PER_BANK - 1 + (b_i - 1) * BLK_PER_BANK + sub_i;
        end
        block = block_t'(blk_i);
    end

endmodule

// File: rtl/flash_op_policy.sv
module flash_op_policy
    import flash_arb_pkg::*;
(
    input  logic     req_valid,
    input  op_e      op,
    input  bank_t    bank,
    input  block_t   block,
    input  slot_t    act,
    input  slot_t    park,
    output verdict_t verdict
);

    logic read_hit;
    logic nest_ok;

    always_comb begin
        // A read collides with the running bank, or with the exact block of a
        // suspended or set-aside operation
        read_hit = 1'b0;
        if (act.valid) begin
            if (act.susp) read_hit = (block == act.block);
            else          read_hit = (bank == act.bank);
        end
        if (park.valid && block == park.block) read_hit = 1'b1;

        nest_ok = act.valid && act.susp && act.op == OP_ERASE &&
                  !park.valid && block != act.block;

        verdict = '0;
        if (req_valid) begin
            unique case (op)
                OP_READ: begin
                    verdict.grant  = !read_hit;
                end
                OP_PROG: begin
                    verdict.grant  = !act.valid || nest_ok;
                    verdict.start  = verdict.grant;
                    verdict.nest   = act.valid && nest_ok;
                end
                OP_ERASE: begin
                    verdict.grant  = !act.valid;
                    verdict.start  = verdict.grant;
                end
                default: begin
                    verdict.grant  = 1'b0;
                end
            endcase
            verdict.reject = !verdict.grant;
        end
    end

endmodule

// File: rtl/flash_busy_tracker.sv
module flash_busy_tracker
    import flash_arb_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  logic   nest,
    input  op_e    op,
    input  bank_t  bank,
    input  block_t block,
    input  logic   eng_done,
    input  logic   eng_suspend,
    input  logic   eng_resume,
    output slot_t  act,
    output slot_t  park
);

    always_ff @(posedge clk) begin
        if (rst) begin
            act  <= '0;
            park <= '0;
        end else if (start) begin
            if (nest) park <= act;
            act <= '{valid: 1'b1, op: op, bank: bank, block: block, susp: 1'b0};
        end else if (act.valid) begin
            if (eng_done && !act.susp) begin
                if (park.valid) begin
                    act  <= park;
                    park <= '0;
                end else begin
                    act  <= '0;
                end
            end else if (eng_suspend && !act.susp) begin
                act.susp <= 1'b1;
            end else if (eng_resume && act.susp) begin
                act.susp <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/flash_bank_arbiter.sv
module flash_bank_arbiter
    import flash_arb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              boot_top,
    input  logic              size_32m,
    input  logic              eng_done,
    input  logic              eng_suspend,
    input  logic              eng_resume,
    output logic              grant,
    output logic              reject,
    output logic [BANK_W-1:0] bank_idx,
    output logic [BLK_W-1:0]  block_idx
);

    op_e      op;
    bank_t    dec_bank;
    block_t   dec_block;
    slot_t    act;
    slot_t    park;
    verdict_t verdict;

    logic     act_valid;
    logic     act_susp;
    bank_t    act_bank;
    logic     park_valid;

    assign op = op_e'(req_op);

    flash_addr_decode u_decode (
        .addr     (req_addr),
        .boot_top (boot_top),
        .size_32m (size_32m),
        .bank     (dec_bank),
        .block    (dec_block)
    );

    flash_op_policy u_policy (
        .req_valid (req_valid),
        .op        (op),
        .bank      (dec_bank),
        .block     (dec_block),
        .act       (act),
        .park      (park),
        .verdict   (verdict)
    );

    flash_busy_tracker u_track (
        .clk         (clk),
        .rst         (rst),
        .start       (verdict.start),
        .nest        (verdict.nest),
        .op          (op),
        .bank        (dec_bank),
        .block       (dec_block),
        .eng_done    (eng_done),
        .eng_suspend (eng_suspend),
        .eng_resume  (eng_resume),
        .act         (act),
        .park        (park)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            grant  <= 1'b0;
            reject <= 1'b0;
        end else begin
            grant  <= verdict.grant;
            reject <= verdict.reject;
        end
    end

    assign bank_idx   = dec_bank;
    assign block_idx  = dec_block;
    assign act_valid  = act.valid;
    assign act_susp   = act.susp;
    assign act_bank   = act.bank;
    assign park_valid = park.valid;

endmodule

// File: rtl/flash_bank_arbiter_chk.sv
module flash_bank_arbiter_chk
    import flash_arb_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic [1:0]       req_op,
    input logic [SUB_W-1:0] addr_sub,
    input logic             boot_top,
    input logic             size_32m,
    input logic             grant,
    input logic             reject,
    input bank_t            bank_idx,
    input block_t           block_idx,
    input logic             act_valid,
    input logic             act_susp,
    input bank_t            act_bank,
    input logic             park_valid
);

    assert_small_array_bank_R1: assert property (@(posedge clk) disable iff (rst)
        !size_32m |-> bank_idx[BANK_W-1] == 1'b0);

    assert_bottom_main_above_params_R2: assert property (@(posedge clk) disable iff (rst)
        (!boot_top && bank_idx != '0) |-> block_idx >= block_t'(PARAM_BLKS + BLK_PER_BANK - 1));

    assert_top_plain_bank_R3: assert property (@(posedge clk) disable iff (rst)
        (boot_top && bank_idx != highest_bank(size_32m)) |->
        (block_idx[BLK_W-1:SUB_W] == (BLK_W-SUB_W)'(bank_idx) && block_idx[SUB_W-1:0] == addr_sub));

    assert_one_verdict_R4: assert property (@(posedge clk) disable iff (rst)
        !(grant && reject));

    assert_verdict_follows_req_R4: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (grant || reject));

    assert_quiet_without_req_R4: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!grant && !reject));

    assert_idle_accepts_R5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op != 2'd0 && req_op != 2'd3 && !act_valid && !park_valid) |=> grant);

    assert_reserved_refused_R6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == 2'd3) |=> reject);

    assert_erase_while_busy_R6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == 2'd2 && act_valid) |=> reject);

    assert_read_busy_bank_R7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == 2'd0 && act_valid && !act_susp && bank_idx == act_bank) |=> reject);

endmodule

bind flash_bank_arbiter flash_bank_arbiter_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_op     (req_op),
    .addr_sub   (req_addr[flash_arb_pkg::BANK_LOG2-1:flash_arb_pkg::MAIN_LOG2]),
    .boot_top   (boot_top),
    .size_32m   (size_32m),
    .grant      (grant),
    .reject     (reject),
    .bank_idx   (bank_idx),
    .block_idx  (block_idx),
    .act_valid  (act_valid),
    .act_susp   (act_susp),
    .act_bank   (act_bank),
    .park_valid (park_valid)
);

// File: tb/tb_flash_bank_arbiter.sv
module tb_flash_bank_arbiter;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'd0;
    logic [20:0] req_addr = '0;
    logic        boot_top = 1'b0;
    logic        size_32m = 1'b0;
    logic        eng_done = 1'b0;
    logic        eng_suspend = 1'b0;
    logic        eng_resume = 1'b0;
    logic        grant;
    logic        reject;
    logic [2:0]  bank_idx;
    logic [6:0]  block_idx;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    flash_bank_arbiter dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .boot_top(boot_top), .size_32m(size_32m),
        .eng_done(eng_done), .eng_suspend(eng_suspend), .eng_resume(eng_resume),
        .grant(grant), .reject(reject), .bank_idx(bank_idx), .block_idx(block_idx)
    );

    localparam logic [1:0] RD = 2'd0, PG = 2'd1, ER = 2'd2, RS = 2'd3;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic top, input logic big);
        @(negedge clk);
        rst = 1'b1; req_valid = 1'b0; boot_top = top; size_32m = big;
        eng_done = 0; eng_suspend = 0; eng_resume = 0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    // Drive a request for one edge, then check the registered verdict
    task automatic req(input string tag, input logic [1:0] op, input logic [20:0] a, input bit exp_grant);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        chk({tag, " grant"}, int'(grant), int'(exp_grant));
        chk({tag, " reject"}, int'(reject), int'(!exp_grant));
    endtask

    task automatic strobe(input int which);
        @(negedge clk);
        if (which == 0) eng_done = 1'b1;
        else if (which == 1) eng_suspend = 1'b1;
        else eng_resume = 1'b1;
        @(negedge clk);
        eng_done = 0; eng_suspend = 0; eng_resume = 0;
    endtask

    task automatic dec(input string tag, input logic [20:0] a, input int eb, input int ek);
        @(negedge clk);
        req_addr = a;
        #1;
        chk({tag, " bank"}, int'(bank_idx), eb);
        chk({tag, " block"}, int'(block_idx), ek);
    endtask

    task automatic t_reset_state;
        do_reset(1'b0, 1'b0);
        #1;
        chk("R4 reset grant", int'(grant), 0);
        chk("R4 reset reject", int'(reject), 0);
        req("R5 program after reset", PG, 21'h40000, 1'b1);
        @(negedge clk);
        chk("R4 idle grant", int'(grant), 0);
        chk("R4 idle reject", int'(reject), 0);
        do_reset(1'b0, 1'b0);
        req("R5 erase after reset", ER, 21'h00000, 1'b1);
    endtask

    task automatic t_decode_bottom;
        do_reset(1'b0, 1'b0);
        dec("R2 first small", 21'h00000, 0, 0);
        dec("R2 last small", 21'h07000, 0, 7);
        dec("R2 first full", 21'h08000, 0, 8);
        dec("R2 last param bank", 21'h3FFFF, 0, 14);
        dec("R2 bank1 start", 21'h40000, 1, 15);
        dec("R2 top of 16M", 21'hFFFFF, 3, 38);
        dec("R1 bit20 ignored", 21'h1FFFFF, 3, 38);
        size_32m = 1'b1;
        dec("R1 32M bank7", 21'h1FFFFF, 7, 70);
        dec("R1 32M bank4", 21'h100000, 4, 39);
    endtask

    task automatic t_decode_top;
        do_reset(1'b1, 1'b0);
        dec("R3 bottom word", 21'h00000, 0, 0);
        dec("R3 bank0 last", 21'h3FFFF, 0, 7);
        dec("R3 param bank start", 21'hC0000, 3, 24);
        dec("R3 first small", 21'hF8000, 3, 31);
        dec("R3 last small", 21'hFFFFF, 3, 38);
        dec("R1 top bit20 ignored", 21'h1C0000, 3, 24);
        size_32m = 1'b1;
        dec("R3 bank3 plain in 32M", 21'hFFFFF, 3, 31);
        dec("R3 32M first small", 21'h1F8000, 7, 63);
        dec("R3 32M last small", 21'h1FFFFF, 7, 70);
    endtask

    task automatic t_busy;
        do_reset(1'b0, 1'b0);
        req("R5 program bank1", PG, 21'h40000, 1'b1);
        req("R7 read other bank", RD, 21'h80000, 1'b1);
        req("R7 read busy bank", RD, 21'h48000, 1'b0);
        req("R6 erase while busy", ER, 21'h80000, 1'b0);
        req("R6 program while busy", PG, 21'hC0000, 1'b0);
        req("R6 reserved code", RS, 21'h80000, 1'b0);
        strobe(0);
        req("R11 program after done", PG, 21'h80000, 1'b1);
    endtask

    task automatic t_prog_suspend;
        do_reset(1'b0, 1'b0);
        req("R5 program block15", PG, 21'h40000, 1'b1);
        strobe(1);
        req("R8 read same bank other block", RD, 21'h48000, 1'b1);
        req("R8 read programmed block", RD, 21'h40010, 1'b0);
        req("R6 program while prog suspended", PG, 21'h80000, 1'b0);
        strobe(2);
        req("R7 read same bank after resume", RD, 21'h48000, 1'b0);
    endtask

    task automatic t_erase_suspend;
        do_reset(1'b0, 1'b0);
        req("R5 erase block23", ER, 21'h80000, 1'b1);
        req("R7 read erasing bank", RD, 21'h88000, 1'b0);
        strobe(1);
        req("R9 read other block", RD, 21'h88000, 1'b1);
        req("R9 program erasing block", PG, 21'h80004, 1'b0);
        req("R6 erase while suspended", ER, 21'h00000, 1'b0);
        req("R9 program other block", PG, 21'h88000, 1'b1);
        req("R7 read nested program bank", RD, 21'h80000, 1'b0);
        req("R7 read elsewhere", RD, 21'h00000, 1'b1);
        strobe(0);
        req("R10 erase still suspended", PG, 21'h90000, 1'b1);
        strobe(0);
        req("R10 erasing block still held", RD, 21'h80000, 1'b0);
        strobe(2);
        req("R10 resumed erase blocks bank", RD, 21'h84000, 1'b0);
        req("R10 read other bank", RD, 21'hC0000, 1'b1);
        strobe(0);
        req("R11 idle after erase", PG, 21'h84000, 1'b1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_decode_bottom();
        t_decode_top();
        t_busy();
        t_prog_suspend();
        t_erase_suspend();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule